// File: doc/BRIEF.md
# Fair-Window Multi-Master Bus Arbiter

This block decides which of several potential bus masters owns a shared bus. Each master has a request line and a grant line, and the master that holds the bus drives a common busy signal. While the bus is free and at least one admitted request is pending, the arbiter runs an arbitration cycle of fixed length. At its end it grants the bus to the requester with the highest priority, where a lower line number means higher priority. The grant stays up until the owner has raised busy and then dropped it.

In the fair mode the arbiter captures the set of requesters at the start of arbitration into a window. A master outside that window is kept out until every captured master has been served. A captured master also leaves the window if it withdraws its request. A run/halt input gates all of this. Under halt no arbitration starts and a cycle in progress is abandoned, but a grant that is already active stays until its owner releases the bus. An arbitration-in-progress flag, the encoded index of the owner and an owner-valid flag are provided for monitoring.

Top module: `fwarb_top`

## Requirements
- R1: After synchronous reset, every grant line, `arb_busy_o` and `owner_valid_o` are low and `owner_idx_o` is zero.
- R2: An arbitration cycle starts on a clock edge only if `run_i` is high, `bus_busy_i` is low, no grant is active and at least one admitted request is high. `arb_busy_o` is high from the clock after that edge.
- R3: `arb_busy_o` stays high for exactly ARB_CYCLES clocks (default 4). The grant appears ARB_CYCLES clocks after the starting edge and never before.
- R4: The grant goes to the lowest-numbered participant that is still requesting. `owner_idx_o` carries its binary index and `owner_valid_o` is high while a grant is active.
- R5: At most one grant line is high at any time. A grant stays high while `bus_busy_i` is high. After busy has been seen high during the grant, a low busy removes the grant on the next clock edge.
- R6: With `fair_i` high, the requests present when arbitration starts are captured into a window, and each member leaves it when granted. While the window is not empty, only its members may take part, so latecomers are served after every captured member, in priority order.
- R7: With `fair_i` low, every arbitration cycle captures all requests present at its start, so a latecomer with a lower number is served before a higher-numbered master that was already waiting.
- R8: While `run_i` is low, no arbitration cycle starts. If `run_i` drops during an arbitration cycle, the cycle is abandoned with no grant and `arb_busy_o` falls on the next clock.
- R9: Dropping `run_i` while a grant is active does not remove the grant. It is still released only through R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | 1 = run, 0 = halt |
| fair_i | input | 1 | 1 = fair window mode, 0 = plain priority mode |
| req_i | input | N_MASTERS | Request line per master |
| bus_busy_i | input | 1 | Driven high by the current owner while it uses the bus |
| grant_o | output | N_MASTERS | One-hot grant, registered |
| arb_busy_o | output | 1 | High while an arbitration cycle runs |
| owner_idx_o | output | IDX_W | Binary index of the granted master |
| owner_valid_o | output | 1 | High while a grant is active |

## Verification
The assertions assume that a granted master raises busy at some point during its grant. They also assume that busy is low whenever the arbiter sits idle and is meant to be able to start, since the start check only looks at the sampled busy level. The stimulus raises busy two clocks after each grant, drops it a few clocks later, and holds busy high in idle only in the case that tests the busy gate. All inputs change on the falling edge, so every sampled level is stable at the rising edge. The sweeps cover each non-empty request pattern of four masters in both modes, with every uncaptured master arriving as a latecomer.

// File: rtl/fwarb_pkg.sv
package fwarb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARB   = 2'd1,
    ST_GRANT = 2'd2
  } arb_state_e;
endpackage

// File: rtl/fwarb_prio.sv
module fwarb_prio #(
  parameter int N_MASTERS = 4,
  localparam int IDX_W = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input  logic [N_MASTERS-1:0] cand_i,
  output logic [N_MASTERS-1:0] pick_o,
  output logic [IDX_W-1:0]     idx_o,
  output logic                 any_o
);
  logic [N_MASTERS:0] taken;

  assign taken[0] = 1'b0;

  for (genvar g = 0; g < N_MASTERS; g++) begin : g_chain
    assign pick_o[g]    = cand_i[g] & ~taken[g];
    assign taken[g+1]   = taken[g] | cand_i[g];
  end

  assign any_o = taken[N_MASTERS];

  always_comb begin
    idx_o = '0;
    for (int i = N_MASTERS - 1; i >= 0; i--) begin
      if (cand_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/fwarb_window.sv
module fwarb_window #(
  parameter int N_MASTERS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run_i,
  input  logic                 fair_i,
  input  logic [N_MASTERS-1:0] req_i,
  input  logic                 load_i,
  input  logic                 hold_i,
  input  logic                 gnt_stb_i,
  input  logic [N_MASTERS-1:0] gnt_vec_i,
  output logic [N_MASTERS-1:0] admitted_o,
  output logic [N_MASTERS-1:0] cand_o
);
  logic [N_MASTERS-1:0] win_q;
  logic [N_MASTERS-1:0] win_live;

  assign win_live = win_q & req_i;
  assign cand_o   = win_live;

  always_comb begin
    if (!run_i)                      admitted_o = '0;
    else if (fair_i && |win_live)    admitted_o = win_live;
    else                             admitted_o = req_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q <= '0;
    end else if (load_i) begin
      win_q <= admitted_o;
    end else if (gnt_stb_i) begin
      win_q <= fair_i ? (win_live & ~gnt_vec_i) : '0;
    end else if (hold_i) begin
      win_q <= win_q;
    end else if (fair_i) begin
      win_q <= win_live;
    end
  end

  assert_window_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (gnt_stb_i && fair_i) |=> ((win_q & $past(gnt_vec_i)) == '0));
endmodule

// File: rtl/fwarb_ctrl.sv
module fwarb_ctrl
  import fwarb_pkg::*;
#(
  parameter int N_MASTERS  = 4,
  parameter int ARB_CYCLES = 4,
  localparam int IDX_W = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1,
  localparam int CNT_W = $clog2(ARB_CYCLES + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run_i,
  input  logic                 bus_busy_i,
  input  logic [N_MASTERS-1:0] admitted_i,
  input  logic [N_MASTERS-1:0] pick_i,
  input  logic [IDX_W-1:0]     pick_idx_i,
  input  logic                 pick_any_i,
  output logic                 load_o,
  output logic                 hold_o,
  output logic                 gnt_stb_o,
  output logic [N_MASTERS-1:0] grant_o,
  output logic                 arb_busy_o,
  output logic [IDX_W-1:0]     owner_idx_o,
  output logic                 owner_valid_o
);
  arb_state_e           state_q, state_d;
  logic [CNT_W-1:0]     cnt_q;
  logic                 seen_busy_q;
  logic                 last_tick;

  assign last_tick = (cnt_q == CNT_W'(ARB_CYCLES - 1));

  always_comb begin
    state_d   = state_q;
    load_o    = 1'b0;
    gnt_stb_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (run_i && !bus_busy_i && |admitted_i) begin
          state_d = ST_ARB;
          load_o  = 1'b1;
        end
      end
      ST_ARB: begin
        if (!run_i) begin
          state_d = ST_IDLE;
        end else if (last_tick) begin
          if (pick_any_i) begin
            state_d   = ST_GRANT;
            gnt_stb_o = 1'b1;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_GRANT: begin
        if (seen_busy_q && !bus_busy_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign hold_o = (state_q == ST_ARB) && !gnt_stb_o && run_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      cnt_q         <= '0;
      seen_busy_q   <= 1'b0;
      grant_o       <= '0;
      arb_busy_o    <= 1'b0;
      owner_idx_o   <= '0;
      owner_valid_o <= 1'b0;
    end else begin
      state_q    <= state_d;
      arb_busy_o <= (state_d == ST_ARB);
      if (load_o)                  cnt_q <= '0;
      else if (state_q == ST_ARB)  cnt_q <= cnt_q + 1'b1;
      if (gnt_stb_o) begin
        grant_o       <= pick_i;
        owner_idx_o   <= pick_idx_i;
        owner_valid_o <= 1'b1;
        seen_busy_q   <= 1'b0;
      end else if (state_q == ST_GRANT) begin
        if (bus_busy_i) seen_busy_q <= 1'b1;
        if (state_d == ST_IDLE) begin
          grant_o       <= '0;
          owner_valid_o <= 1'b0;
          seen_busy_q   <= 1'b0;
        end
      end
    end
  end

  assert_onehot_grant_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_o));

  assert_hold_while_busy_R5: assert property (@(posedge clk) disable iff (rst)
    (|grant_o && bus_busy_i) |=> $stable(grant_o));

  assert_start_gate_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(arb_busy_o) |-> $past(run_i && !bus_busy_i && !(|grant_o)));

  assert_grant_after_arb_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(owner_valid_o) |-> $past(arb_busy_o));

  assert_halt_keeps_grant_R9: assert property (@(posedge clk) disable iff (rst)
    (|grant_o && !run_i && bus_busy_i) |=> |grant_o);
endmodule

// File: rtl/fwarb_top.sv
module fwarb_top #(
  parameter int N_MASTERS  = 4,
  parameter int ARB_CYCLES = 4,
  localparam int IDX_W = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run_i,
  input  logic                 fair_i,
  input  logic [N_MASTERS-1:0] req_i,
  input  logic                 bus_busy_i,
  output logic [N_MASTERS-1:0] grant_o,
  output logic                 arb_busy_o,
  output logic [IDX_W-1:0]     owner_idx_o,
  output logic                 owner_valid_o
);
  logic [N_MASTERS-1:0] admitted;
  logic [N_MASTERS-1:0] cand;
  logic [N_MASTERS-1:0] pick;
  logic [IDX_W-1:0]     pick_idx;
  logic                 pick_any;
  logic                 load;
  logic                 hold;
  logic                 gnt_stb;

  fwarb_window #(.N_MASTERS(N_MASTERS)) u_window (
    .clk        (clk),
    .rst        (rst),
    .run_i      (run_i),
    .fair_i     (fair_i),
    .req_i      (req_i),
    .load_i     (load),
    .hold_i     (hold),
    .gnt_stb_i  (gnt_stb),
    .gnt_vec_i  (pick),
    .admitted_o (admitted),
    .cand_o     (cand)
  );

  fwarb_prio #(.N_MASTERS(N_MASTERS)) u_prio (
    .cand_i (cand),
    .pick_o (pick),
    .idx_o  (pick_idx),
    .any_o  (pick_any)
  );

  fwarb_ctrl #(.N_MASTERS(N_MASTERS), .ARB_CYCLES(ARB_CYCLES)) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .run_i         (run_i),
    .bus_busy_i    (bus_busy_i),
    .admitted_i    (admitted),
    .pick_i        (pick),
    .pick_idx_i    (pick_idx),
    .pick_any_i    (pick_any),
    .load_o        (load),
    .hold_o        (hold),
    .gnt_stb_o     (gnt_stb),
    .grant_o       (grant_o),
    .arb_busy_o    (arb_busy_o),
    .owner_idx_o   (owner_idx_o),
    .owner_valid_o (owner_valid_o)
  );
endmodule

// File: tb/sim_fwarb_top.sv
`timescale 1ns/1ps
module sim_fwarb_top;
  localparam int N  = 4;
  localparam int AC = 4;
  localparam logic [N-1:0] ALL = '1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         run_i = 1'b0;
  logic         fair_i = 1'b0;
  logic [N-1:0] req_i = '0;
  logic         bus_busy_i = 1'b0;
  logic [N-1:0] grant_o;
  logic         arb_busy_o;
  logic [1:0]   owner_idx_o;
  logic         owner_valid_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fwarb_top #(.N_MASTERS(N), .ARB_CYCLES(AC)) u0 (
    .clk(clk), .rst(rst), .run_i(run_i), .fair_i(fair_i), .req_i(req_i),
    .bus_busy_i(bus_busy_i), .grant_o(grant_o), .arb_busy_o(arb_busy_o),
    .owner_idx_o(owner_idx_o), .owner_valid_o(owner_valid_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Starts at a negedge with the bus idle and requests set up.
  task automatic serve_one(input int e, input logic [N-1:0] late, input string tag);
    @(posedge clk); @(negedge clk);
    chk({tag, " R2 arb_busy after start"}, 32'(arb_busy_o), 32'd1);
    repeat (AC - 1) @(posedge clk);
    @(negedge clk);
    chk({tag, " R3 no early grant"}, 32'(grant_o), 32'd0);
    @(posedge clk); @(negedge clk);
    chk({tag, " R4 grant vector"}, 32'(grant_o), 32'(1 << e));
    chk({tag, " R4 owner index"}, 32'(owner_idx_o), 32'(e));
    chk({tag, " R3 arb_busy low at grant"}, 32'(arb_busy_o), 32'd0);
    req_i = (req_i & ~(N'(1) << e)) | late;
    @(negedge clk);
    bus_busy_i = 1'b1;
    repeat (2) @(negedge clk);
    chk({tag, " R5 held while busy"}, 32'(grant_o), 32'(1 << e));
    bus_busy_i = 1'b0;
    @(posedge clk); @(negedge clk);
    chk({tag, " R5 released"}, 32'(grant_o), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 grant after reset", 32'(grant_o), 32'd0);
    chk("R1 arb_busy after reset", 32'(arb_busy_o), 32'd0);
    chk("R1 owner_valid after reset", 32'(owner_valid_o), 32'd0);
    chk("R1 owner_idx after reset", 32'(owner_idx_o), 32'd0);

    // R8: halt blocks arbitration
    req_i = 4'b0010;
    repeat (6) begin
      @(negedge clk);
      chk("R8 halt no arb", 32'(arb_busy_o), 32'd0);
    end
    run_i = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R8 arb after run", 32'(arb_busy_o), 32'd1);
    run_i = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R8 abandoned arb", 32'(arb_busy_o), 32'd0);
    repeat (6) begin
      @(negedge clk);
      chk("R8 no grant after abandon", 32'(grant_o), 32'd0);
    end
    run_i = 1'b1;
    serve_one(1, '0, "halt-resume");

    // R2: busy bus blocks the start
    bus_busy_i = 1'b1;
    req_i = 4'b1000;
    repeat (5) begin
      @(negedge clk);
      chk("R2 busy blocks start", 32'(arb_busy_o), 32'd0);
    end
    bus_busy_i = 1'b0;
    serve_one(3, '0, "busy-gate");

    // R9: halt during grant keeps it
    req_i = 4'b0001;
    @(posedge clk); @(negedge clk);
    repeat (AC) @(posedge clk);
    @(negedge clk);
    chk("R9 grant present", 32'(grant_o), 32'd1);
    run_i = 1'b0;
    bus_busy_i = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk("R9 grant kept under halt", 32'(grant_o), 32'd1);
    end
    bus_busy_i = 1'b0;
    @(negedge clk);
    chk("R5 release under halt", 32'(grant_o), 32'd0);
    repeat (6) begin
      @(negedge clk);
      chk("R8 no new arb under halt", 32'(arb_busy_o), 32'd0);
    end
    run_i = 1'b1;
    serve_one(0, '0, "after-halt");

    // R7: plain priority sweep
    fair_i = 1'b0;
    for (int p = 1; p < 16; p++) begin
      int first;
      int k;
      first = 0;
      while (((p >> first) & 1) == 0) first++;
      req_i = N'(p);
      serve_one(first, ~N'(p) & ALL, $sformatf("R7 plain p=%0d", p));
      k = 0;
      for (int i = 0; i < N; i++) begin
        if (i != first) begin
          serve_one(i, '0, $sformatf("R7 plain p=%0d step=%0d", p, k));
          k++;
        end
      end
    end

    // R6: fair window sweep
    fair_i = 1'b1;
    for (int p = 1; p < 16; p++) begin
      int order[N];
      int n;
      n = 0;
      for (int i = 0; i < N; i++) if ((p >> i) & 1) begin order[n] = i; n++; end
      for (int i = 0; i < N; i++) if (!((p >> i) & 1)) begin order[n] = i; n++; end
      req_i = N'(p);
      for (int k = 0; k < N; k++) begin
        serve_one(order[k], (k == 0) ? (~N'(p) & ALL) : '0,
                  $sformatf("R6 fair p=%0d step=%0d", p, k));
      end
    end

    repeat (3) @(negedge clk);
    chk("R4 owner_valid idle", 32'(owner_valid_o), 32'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule